// File: doc/BRIEF.md
# Indirect Analog Control Register Port

This block puts a bank of thirty-two 8-bit analog control registers behind one 32-bit host word. The host never addresses the bank directly. Each access rewrites the whole word: one bit releases the bank from reset, one bit selects read or write, a 5-bit field selects the internal register, and an 8-bit field carries the value to store. The low byte of the word is read-only. It always shows the contents of the register that the address field currently selects.

A read is one host write with the direction bit at 0 and the wanted address, followed by a host read of the low byte. A write takes two host writes. The first sets the address and data with the direction bit at 0. The second repeats the same word with the direction bit at 1, and that edge of the direction bit stores the byte.

A sequencer tracks the host word in three states. HELD means the bank is in reset. READ means the bank is released with direction 0. WRITE means the bank is released with direction 1. The transitions are named:
- release: HELD to READ or to WRITE.
- arm-commit: READ to WRITE.
- retarget: WRITE to WRITE with a changed address or data.
- disarm: WRITE to READ.
- hold-reset: any state to HELD.

Only arm-commit and retarget store a byte. Hold-reset clears the whole bank.

Top module: `ana_ind_port`

## Requirements
- R1: After the reset input, the host word reads as all zeros.
- R2: A host write stores bit 28 (release), bit 24 (direction, 1 = write), bits 20:16 (address) and bits 15:8 (write data). These read back in the same positions. All other bits of bits 31:8 read 0, and the value written to bits 7:0 has no effect. Without a host write, the word holds its value.
- R3: A host write with bit 28 = 0 clears all 32 internal registers. While bit 28 is 0, bits 7:0 read 0.
- R4: A host write with bit 28 = 1 and bit 24 = 1, made while the word holds bit 28 = 1 and bit 24 = 0, stores bits 15:8 into the register addressed by bits 20:16. The new value shows in bits 7:0 after that write.
- R5: While the word holds bit 28 = 1 and bit 24 = 1, a further write with bit 24 = 1 stores again only when the address or data field differs from the held word.
- R6: A write with bit 24 = 0 never changes any internal register.
- R7: A write that takes bit 28 from 0 to 1 stores nothing, even when it also sets bit 24 = 1.
- R8: Bits 7:0 follow the address field of the current word. The first read after an address change shows the newly addressed register.
- R9: A store changes only the addressed register. Each of the 32 registers keeps its own value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe for the control word |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Current control word, with the addressed register in bits 7:0 |

## Verification
Nearly every internal fault surfaces in the low byte of `host_rdata` one cycle after the host write that caused it. A missed or extra store shows as a wrong byte on the next read of that address. A store decoded to the wrong register corrupts a neighbour, which a full sweep of all 32 addresses exposes. A sequencer state that is out of step with the stored word shows as a store that is missing or spurious at the step of the two-write protocol where it goes wrong. A clear that fails to happen leaves nonzero bytes that are visible once the bank is released.

// File: rtl/acp_pkg.sv
package acp_pkg;
    localparam int WORD_W   = 32;
    localparam int REL_BIT  = 28;
    localparam int DIR_BIT  = 24;
    localparam int ADDR_LSB = 16;
    localparam int WDAT_LSB = 8;

    typedef enum logic [1:0] {
        ST_HELD  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } acp_state_e;
endpackage

// File: rtl/acp_host_word.sv
module acp_host_word #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [31:0]       wdata,
    output logic              n_rel,
    output logic              n_dir,
    output logic [ADDR_W-1:0] n_addr,
    output logic [DATA_W-1:0] n_wdat,
    output logic              q_rel,
    output logic              q_dir,
    output logic [ADDR_W-1:0] q_addr,
    output logic [DATA_W-1:0] q_wdat
);
    import acp_pkg::*;

    // Field slices of the incoming host value
    assign n_rel  = wdata[REL_BIT];
    assign n_dir  = wdata[DIR_BIT];
    assign n_addr = wdata[ADDR_LSB +: ADDR_W];
    assign n_wdat = wdata[WDAT_LSB +: DATA_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_rel  <= 1'b0;
            q_dir  <= 1'b0;
            q_addr <= '0;
            q_wdat <= '0;
        end else if (we) begin
            q_rel  <= n_rel;
            q_dir  <= n_dir;
            q_addr <= n_addr;
            q_wdat <= n_wdat;
        end
    end
endmodule

// File: rtl/acp_seq.sv
module acp_seq #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic                n_rel,
    input  logic                n_dir,
    input  logic [ADDR_W-1:0]   n_addr,
    input  logic [DATA_W-1:0]   n_wdat,
    input  logic [ADDR_W-1:0]   q_addr,
    input  logic [DATA_W-1:0]   q_wdat,
    output logic                commit,
    output logic                clear_all,
    output acp_pkg::acp_state_e state
);
    import acp_pkg::*;

    acp_state_e state_q, state_d;
    logic       changed;

    assign changed = (n_addr != q_addr) || (n_wdat != q_wdat);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HELD;
        else        state_q <= state_d;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        if (we) begin
            if (!n_rel)     state_d = ST_HELD;
            else if (n_dir) state_d = ST_WRITE;
            else            state_d = ST_READ;
        end
    end

    // Outputs: arm-commit and retarget store; hold-reset clears
    always_comb begin
        commit    = 1'b0;
        clear_all = 1'b0;
        if (we) begin
            unique case (state_q)
                ST_HELD: begin
                    clear_all = !n_rel;
                end
                ST_READ: begin
                    clear_all = !n_rel;
                    commit    = n_rel && n_dir;
                end
                ST_WRITE: begin
                    clear_all = !n_rel;
                    commit    = n_rel && n_dir && changed;
                end
                default: begin
                    clear_all = 1'b1;
                end
            endcase
        end
    end

    assign state = state_q;
endmodule

// File: rtl/acp_bank.sv
module acp_bank #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic              commit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_dat,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_dat
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        logic hit;
        assign hit = commit && (wr_addr == ADDR_W'(i));
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all) regs[i] <= '0;
            else if (hit)            regs[i] <= wr_dat;
        end
    end

    assign rd_dat = regs[rd_addr];
endmodule

// File: rtl/ana_ind_port.sv
module ana_ind_port #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata
);
    import acp_pkg::*;

    logic              n_rel, n_dir, q_rel, q_dir;
    logic [ADDR_W-1:0] n_addr, q_addr;
    logic [DATA_W-1:0] n_wdat, q_wdat, rd_dat;
    logic              commit, clear_all;
    acp_state_e        state;

    acp_host_word #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_word (
        .clk(clk), .rst_n(rst_n), .we(host_we), .wdata(host_wdata),
        .n_rel(n_rel), .n_dir(n_dir), .n_addr(n_addr), .n_wdat(n_wdat),
        .q_rel(q_rel), .q_dir(q_dir), .q_addr(q_addr), .q_wdat(q_wdat)
    );

    acp_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .we(host_we),
        .n_rel(n_rel), .n_dir(n_dir), .n_addr(n_addr), .n_wdat(n_wdat),
        .q_addr(q_addr), .q_wdat(q_wdat),
        .commit(commit), .clear_all(clear_all), .state(state)
    );

    acp_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .commit(commit),
        .wr_addr(n_addr), .wr_dat(n_wdat), .rd_addr(q_addr), .rd_dat(rd_dat)
    );

    logic unused_state;
    assign unused_state = ^{state, q_dir};

    always_comb begin
        host_rdata                        = '0;
        host_rdata[REL_BIT]               = q_rel;
        host_rdata[DIR_BIT]               = q_dir;
        host_rdata[ADDR_LSB +: ADDR_W]    = q_addr;
        host_rdata[WDAT_LSB +: DATA_W]    = q_wdat;
        host_rdata[DATA_W-1:0]            = rd_dat;
    end
endmodule

// File: rtl/ana_ind_port_chk.sv
module ana_ind_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_we,
    input logic [31:0] host_wdata,
    input logic [31:0] host_rdata
);
    localparam logic [31:0] FIELD_MASK = 32'h111F_FF00;

    a_r1_reset_zero: assert property (@(posedge clk)
        $rose(rst_n) |-> host_rdata == 32'h0);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !host_we |=> $stable(host_rdata));

    a_r2_fields: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |=> host_rdata[31:8] == ($past(host_wdata[31:8]) & FIELD_MASK[31:8]));

    a_r3_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rdata[28] |-> host_rdata[7:0] == 8'h0);

    a_r4_commit: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && host_wdata[28] && host_wdata[24] && host_rdata[28] && !host_rdata[24]
        |=> host_rdata[7:0] == $past(host_wdata[15:8]));

    a_r5_retarget: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && host_wdata[28] && host_wdata[24] && host_rdata[28] && host_rdata[24]
        && (host_wdata[20:8] != host_rdata[20:8])
        |=> host_rdata[7:0] == $past(host_wdata[15:8]));

    a_r6_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && host_wdata[28] && !host_wdata[24] && host_rdata[28]
        && host_wdata[20:16] == host_rdata[20:16]
        |=> $stable(host_rdata[7:0]));

    a_r7_release_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && !host_rdata[28] |=> host_rdata[7:0] == 8'h0);
endmodule

bind ana_ind_port ana_ind_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
);

// File: tb/ana_ind_port_test.sv
module ana_ind_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [32];

    always #2 clk = ~clk;

    ana_ind_port uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    function automatic logic [31:0] mk(input logic rel, input logic dir,
                                       input logic [4:0] a, input logic [7:0] d);
        return {3'b0, rel, 3'b0, dir, 3'b0, a, d, 8'h00};
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) ^ 8'h5A);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic hw(input logic [31:0] w);
        @(negedge clk);
        host_we    = 1'b1;
        host_wdata = w;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic store(input int a, input logic [7:0] d);
        hw(mk(1'b1, 1'b0, 5'(a), d));
        hw(mk(1'b1, 1'b1, 5'(a), d));
    endtask

    task automatic rd_chk(input string req, input int a, input logic [7:0] exp);
        hw(mk(1'b1, 1'b0, 5'(a), 8'h00));
        chk(req, {24'h0, host_rdata[7:0]}, {24'h0, exp});
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 8'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", host_rdata, 32'h0);

        // R7 / R2: release with direction set, all bits high
        hw(32'hFFFF_FFFF);
        chk("R2", host_rdata, 32'h111F_FF00);
        chk("R7", {24'h0, host_rdata[7:0]}, 32'h0);
        rd_chk("R7", 31, 8'h00);

        // R2: hold without strobe
        @(negedge clk);
        chk("R2", host_rdata, 32'h101F_0000);

        // R4 / R9: full sweep of stores then reads
        for (int a = 0; a < 32; a++) begin
            store(a, pat(a));
            model[a] = pat(a);
            chk("R4", {24'h0, host_rdata[7:0]}, {24'h0, pat(a)});
        end
        for (int a = 0; a < 32; a++) rd_chk("R9", a, model[a]);

        // R8: address change visible on the first read
        for (int a = 31; a >= 0; a--) begin
            hw(mk(1'b1, 1'b0, 5'(a), 8'hC3));
            chk("R8", {24'h0, host_rdata[7:0]}, {24'h0, model[a]});
        end

        // R6: read-mode writes with data never store
        hw(mk(1'b1, 1'b0, 5'd5, 8'hEE));
        hw(mk(1'b1, 1'b0, 5'd5, 8'h11));
        rd_chk("R6", 5, model[5]);

        // R2: low-byte writes ignored
        hw(mk(1'b1, 1'b0, 5'd6, 8'h00) | 32'h0000_00FF);
        chk("R2", host_rdata, mk(1'b1, 1'b0, 5'd6, 8'h00) | {24'h0, model[6]});

        // R5: retarget while in write mode
        store(3, 8'h77);
        model[3] = 8'h77;
        hw(mk(1'b1, 1'b1, 5'd3, 8'h99));
        model[3] = 8'h99;
        chk("R5", {24'h0, host_rdata[7:0]}, 32'h99);
        hw(mk(1'b1, 1'b1, 5'd4, 8'h42));
        model[4] = 8'h42;
        chk("R5", {24'h0, host_rdata[7:0]}, 32'h42);
        hw(mk(1'b1, 1'b1, 5'd4, 8'h42));
        chk("R5", {24'h0, host_rdata[7:0]}, 32'h42);
        rd_chk("R5", 3, 8'h99);
        rd_chk("R9", 2, model[2]);

        // R3: hold-reset clears the whole bank
        hw(mk(1'b0, 1'b0, 5'd4, 8'h00));
        chk("R3", host_rdata, mk(1'b0, 1'b0, 5'd4, 8'h00));
        hw(mk(1'b0, 1'b1, 5'd9, 8'h55));
        chk("R3", {24'h0, host_rdata[7:0]}, 32'h0);
        for (int a = 0; a < 32; a++) rd_chk("R3", a, 8'h00);

        // Store still works after re-release
        store(17, 8'hA5);
        chk("R4", {24'h0, host_rdata[7:0]}, 32'hA5);
        rd_chk("R9", 16, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule